// File: doc/BRIEF.md
# I2C Register-Bank Target with General-Call Command

This block is an I2C target that gives a local processor two byte-wide register banks on a two-wire bus. The bus controller writes into one bank, the write bank, and reads from the other, the read bank. Both banks use one shared register pointer. The first data byte of a write transfer loads the pointer. After that, each byte moves it forward: bytes written are stored at the pointer, and bytes read are taken from it. A read that ends with a NACK from the controller returns the pointer to zero. This makes the next plain read start at the bottom of the read bank.

When the general-call address is enabled, the block also acknowledges it. Every data byte that follows a general call goes into one command register and does not touch either bank. The local side receives the following outputs:
- the whole write bank, as a flat vector;
- the last general-call command;
- the last pointer value written by the controller;
- busy flags for reads and for writes;
- a sticky "data was read" flag, which the local side clears with a pulse.

The local side also supplies the read bank as a flat input vector. SCL and SDA are oversampled by the system clock through synchronizer chains. The block drives only SDA, and only low, through an open-drain enable. It never stretches SCL.

Top module: `i2c_regbank_target`

## Requirements
- R1: `cfg_addr[7:1]` holds the 7-bit target address. `cfg_addr[0]` set enables acceptance of the general-call address byte 0x00. When bit 0 is clear, 0x00 is not acknowledged.
- R2: An address byte whose bits 7:1 match `cfg_addr[7:1]` is acknowledged by pulling SDA low during the ninth clock. Any other address byte (other than an enabled general call) is not acknowledged. The block then drives nothing and changes nothing until the next START.
- R3: In a write transfer to the own address (bit 0 of the address byte = 0), the first data byte is acknowledged. It loads the register pointer and also appears on `last_ptr`.
- R4: Each later data byte of that write transfer is acknowledged and stored in the write bank at entry (pointer mod `WR_DEPTH`). The pointer then increments by one, wrapping at 256. Bank depths are powers of two.
- R5: The own address with bit 0 = 1 sets `rd_busy`. The block then sends read-bank entry (pointer mod `RD_DEPTH`), MSB first, and increments the pointer after each byte it loads. Each byte the controller acknowledges is followed by the next entry.
- R6: A NACK from the controller after a transmitted byte returns the block to idle with SDA released. It also sets the pointer to 0, clears `rd_busy` and sets `data_was_read`.
- R7: `data_was_read` stays set until a one-cycle pulse on `clr_was_read` clears it.
- R8: The own address with bit 0 = 0 sets `wr_busy`. A STOP or a repeated START clears it.
- R9: After an acknowledged general call, every data byte is acknowledged and stored in `gc_cmd`. The write bank, pointer and `last_ptr` are left unchanged.
- R10: After reset, all outputs are zero and SDA is released. SDA is pulled low only in an acknowledge slot or for a zero data bit being transmitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_addr | input | 8 | Target address in 7:1, general-call enable in 0 |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| rd_bank | input | RD_DEPTH*8 | Read-bank contents, entry k in bits 8k+7:8k |
| wr_bank | output | WR_DEPTH*8 | Write-bank contents, entry k in bits 8k+7:8k |
| gc_cmd | output | 8 | Last general-call data byte |
| last_ptr | output | 8 | Last pointer byte written by the controller |
| rd_busy | output | 1 | A read transfer is in progress |
| wr_busy | output | 1 | A write transfer to the own address is in progress |
| data_was_read | output | 1 | Sticky flag: a read ended with NACK |
| clr_was_read | input | 1 | Pulse to clear `data_was_read` |

## Verification
The embedded properties check the following on every cycle:
- SDA stays released while the block is idle.
- SDA is driven only in the acknowledge and transmit phases.
- A controller NACK zeroes the pointer and updates both read flags on the next cycle.
- The sticky flag holds until cleared.
- START and STOP clear the write-busy flag.
- General-call bytes never raise a bank write.

Only the bench scenarios can show the rest, because it depends on whole transfers:
- that the right bytes land at the right indices;
- that read data comes back in order across the wrap points;
- that mismatched or disabled addresses go unacknowledged and leave all state untouched;
- that a repeated START lets a pointer write be followed by a read.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;

   // Bit-level phase of the bus engine
   typedef enum logic [2:0] {
      PH_IDLE,   // ignoring the bus until START
      PH_RX,     // shifting in a byte from the controller
      PH_RACK,   // holding SDA low for our acknowledge
      PH_TX,     // shifting out a read-bank byte
      PH_TACK    // waiting for the controller's ACK/NACK
   } phase_e;

   // Transfer-level state
   typedef enum logic [2:0] {
      TR_ADDR,   // next byte is an address byte
      TR_PTR,    // next byte loads the pointer
      TR_WDATA,  // next bytes fill the write bank
      TR_READ,   // sending read-bank bytes
      TR_GCALL   // next bytes go to the command register
   } xfer_e;

   // Synchronised bus events, one cycle wide
   typedef struct packed {
      logic start;
      logic stop;
      logic rise;
      logic fall;
      logic sda;
   } bus_ev_t;

endpackage

// File: rtl/i2ct_sync.sv
module i2ct_sync
   import i2ct_pkg::*;
#(
   parameter int STAGES = 2
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    scl_i,
   input  logic    sda_i,
   output bus_ev_t ev
);

   localparam int LAST = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("i2ct_sync: STAGES must be at least 2");
   end

   logic [LAST:0] scl_q, sda_q;
   logic          scl_d, sda_d;

   // Both lines go through identical chains so their edges stay aligned
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= '1;
         sda_q <= '1;
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_q <= {scl_q[LAST-1:0], scl_i};
         sda_q <= {sda_q[LAST-1:0], sda_i};
         scl_d <= scl_q[LAST];
         sda_d <= sda_q[LAST];
      end
   end

   always_comb begin
      ev.rise  = scl_q[LAST] & ~scl_d;
      ev.fall  = ~scl_q[LAST] & scl_d;
      ev.start = scl_q[LAST] & scl_d & sda_d & ~sda_q[LAST];
      ev.stop  = scl_q[LAST] & scl_d & ~sda_d & sda_q[LAST];
      ev.sda   = sda_q[LAST];
   end

endmodule

// File: rtl/i2ct_wbank.sv
module i2ct_wbank #(
   parameter int DEPTH = 16,
   localparam int IW = $clog2(DEPTH)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 we,
   input  logic [IW-1:0]        idx,
   input  logic [7:0]           wdata,
   output logic [DEPTH*8-1:0]   flat
);

   for (genvar g = 0; g < DEPTH; g++) begin : g_ent
      logic [7:0] r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                       r <= 8'h00;
         else if (we && idx == IW'(g))     r <= wdata;
      end
      assign flat[g*8 +: 8] = r;
   end

endmodule

// File: rtl/i2ct_rmux.sv
module i2ct_rmux #(
   parameter int DEPTH = 16,
   localparam int IW = $clog2(DEPTH)
) (
   input  logic [DEPTH*8-1:0] flat,
   input  logic [IW-1:0]      idx,
   output logic [7:0]         q
);

   assign q = flat[{idx, 3'b000} +: 8];

endmodule

// File: rtl/i2c_regbank_target.sv
module i2c_regbank_target
   import i2ct_pkg::*;
#(
   parameter int WR_DEPTH    = 16,
   parameter int RD_DEPTH    = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [7:0]            cfg_addr,
   input  logic                  scl_i,
   input  logic                  sda_i,
   output logic                  sda_oe,
   input  logic [RD_DEPTH*8-1:0] rd_bank,
   output logic [WR_DEPTH*8-1:0] wr_bank,
   output logic [7:0]            gc_cmd,
   output logic [7:0]            last_ptr,
   output logic                  rd_busy,
   output logic                  wr_busy,
   output logic                  data_was_read,
   input  logic                  clr_was_read
);

   localparam int WIW = $clog2(WR_DEPTH);
   localparam int RIW = $clog2(RD_DEPTH);

   // Elaboration-time parameter checks
   if (WR_DEPTH < 2 || WR_DEPTH > 256 || (WR_DEPTH & (WR_DEPTH - 1)) != 0) begin : g_bad_wd
      $error("i2c_regbank_target: WR_DEPTH must be a power of two in 2..256");
   end
   if (RD_DEPTH < 2 || RD_DEPTH > 256 || (RD_DEPTH & (RD_DEPTH - 1)) != 0) begin : g_bad_rd
      $error("i2c_regbank_target: RD_DEPTH must be a power of two in 2..256");
   end

   bus_ev_t          ev;
   phase_e           phase;
   xfer_e            tstate;
   logic [3:0]       bitcnt;
   logic [6:0]       shreg;
   logic [6:0]       tx_sh;
   logic             ack_q;
   logic [7:0]       ptr;
   logic             wb_we;
   logic [WIW-1:0]   wb_idx;
   logic [7:0]       wb_data;
   logic [7:0]       rd_sel;
   logic [7:0]       rx_byte;

   i2ct_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .scl_i (scl_i),
      .sda_i (sda_i),
      .ev    (ev)
   );

   i2ct_wbank #(.DEPTH(WR_DEPTH)) u_wbank (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wb_we),
      .idx   (wb_idx),
      .wdata (wb_data),
      .flat  (wr_bank)
   );

   i2ct_rmux #(.DEPTH(RD_DEPTH)) u_rmux (
      .flat (rd_bank),
      .idx  (ptr[RIW-1:0]),
      .q    (rd_sel)
   );

   assign rx_byte = {shreg, ev.sda};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase         <= PH_IDLE;
         tstate        <= TR_ADDR;
         bitcnt        <= 4'd0;
         shreg         <= 7'd0;
         tx_sh         <= 7'd0;
         ack_q         <= 1'b0;
         ptr           <= 8'd0;
         sda_oe        <= 1'b0;
         wb_we         <= 1'b0;
         wb_idx        <= '0;
         wb_data       <= 8'd0;
         gc_cmd        <= 8'd0;
         last_ptr      <= 8'd0;
         rd_busy       <= 1'b0;
         wr_busy       <= 1'b0;
         data_was_read <= 1'b0;
      end else begin
         wb_we <= 1'b0;
         if (clr_was_read) data_was_read <= 1'b0;

         if (ev.start) begin
            phase   <= PH_RX;
            tstate  <= TR_ADDR;
            bitcnt  <= 4'd0;
            sda_oe  <= 1'b0;
            wr_busy <= 1'b0;
         end else if (ev.stop) begin
            phase   <= PH_IDLE;
            tstate  <= TR_ADDR;
            sda_oe  <= 1'b0;
            wr_busy <= 1'b0;
         end else begin
            unique case (phase)
               PH_RX: begin
                  if (ev.rise) begin
                     shreg <= rx_byte[6:0];
                     if (bitcnt == 4'd7) begin
                        bitcnt <= 4'd8;
                        ack_q  <= 1'b1;
                        unique case (tstate)
                           TR_ADDR: begin
                              if (rx_byte[7:1] == cfg_addr[7:1]) begin
                                 if (rx_byte[0]) begin
                                    tstate  <= TR_READ;
                                    rd_busy <= 1'b1;
                                 end else begin
                                    tstate  <= TR_PTR;
                                    wr_busy <= 1'b1;
                                 end
                              end else if (rx_byte == 8'h00 && cfg_addr[0]) begin
                                 tstate <= TR_GCALL;
                              end else begin
                                 ack_q <= 1'b0;
                              end
                           end
                           TR_PTR: begin
                              ptr      <= rx_byte;
                              last_ptr <= rx_byte;
                              tstate   <= TR_WDATA;
                           end
                           TR_WDATA: begin
                              wb_we   <= 1'b1;
                              wb_idx  <= ptr[WIW-1:0];
                              wb_data <= rx_byte;
                              ptr     <= ptr + 8'd1;
                           end
                           TR_GCALL: gc_cmd <= rx_byte;
                           default:  ack_q  <= 1'b0;
                        endcase
                     end else begin
                        bitcnt <= bitcnt + 4'd1;
                     end
                  end else if (ev.fall && bitcnt == 4'd8) begin
                     if (ack_q) begin
                        sda_oe <= 1'b1;
                        phase  <= PH_RACK;
                     end else begin
                        phase  <= PH_IDLE;
                        tstate <= TR_ADDR;
                     end
                  end
               end
               PH_RACK: begin
                  if (ev.fall) begin
                     if (tstate == TR_READ) begin
                        tx_sh  <= rd_sel[6:0];
                        sda_oe <= ~rd_sel[7];
                        ptr    <= ptr + 8'd1;
                        bitcnt <= 4'd0;
                        phase  <= PH_TX;
                     end else begin
                        sda_oe <= 1'b0;
                        bitcnt <= 4'd0;
                        phase  <= PH_RX;
                     end
                  end
               end
               PH_TX: begin
                  if (ev.fall) begin
                     if (bitcnt == 4'd7) begin
                        sda_oe <= 1'b0;
                        phase  <= PH_TACK;
                     end else begin
                        sda_oe <= ~tx_sh[6];
                        tx_sh  <= {tx_sh[5:0], 1'b0};
                        bitcnt <= bitcnt + 4'd1;
                     end
                  end
               end
               PH_TACK: begin
                  if (ev.rise && ev.sda) begin
                     phase         <= PH_IDLE;
                     tstate        <= TR_ADDR;
                     ptr           <= 8'd0;
                     rd_busy       <= 1'b0;
                     data_was_read <= 1'b1;
                     sda_oe        <= 1'b0;
                  end else if (ev.fall) begin
                     tx_sh  <= rd_sel[6:0];
                     sda_oe <= ~rd_sel[7];
                     ptr    <= ptr + 8'd1;
                     bitcnt <= 4'd0;
                     phase  <= PH_TX;
                  end
               end
               default: sda_oe <= 1'b0;
            endcase
         end
      end
   end

   // ---------------- assertions ----------------
   p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_IDLE) |-> !sda_oe);

   p_drive_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
      sda_oe |-> (phase == PH_RACK || phase == PH_TX));

   p_nack_resets_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_TACK && ev.rise && ev.sda) |=> (ptr == 8'd0 && !rd_busy && data_was_read));

   p_flag_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (data_was_read && !clr_was_read) |=> data_was_read);

   p_busy_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ev.start || ev.stop) |=> !wr_busy);

   p_gcall_no_bank_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (tstate == TR_GCALL) |-> !wb_we);

endmodule

// File: tb/i2c_regbank_target_tb_top.sv
module i2c_regbank_target_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int WD = 16;
   localparam int RD = 16;
   localparam int H  = 8;   // system clocks per SCL half-phase

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic            m_scl = 1'b1;
   logic            m_sda = 1'b1;
   logic [7:0]      cfg_addr = 8'h55;
   logic            clr_was_read = 1'b0;
   logic            sda_oe;
   logic [RD*8-1:0] rd_bank;
   logic [WD*8-1:0] wr_bank;
   logic [7:0]      gc_cmd, last_ptr;
   logic            rd_busy, wr_busy, data_was_read;
   logic            bus_sda;

   assign bus_sda = m_sda & ~sda_oe;   // wired-AND bus

   i2c_regbank_target #(.WR_DEPTH(WD), .RD_DEPTH(RD)) dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .cfg_addr      (cfg_addr),
      .scl_i         (m_scl),
      .sda_i         (bus_sda),
      .sda_oe        (sda_oe),
      .rd_bank       (rd_bank),
      .wr_bank       (wr_bank),
      .gc_cmd        (gc_cmd),
      .last_ptr      (last_ptr),
      .rd_busy       (rd_busy),
      .wr_busy       (wr_busy),
      .data_was_read (data_was_read),
      .clr_was_read  (clr_was_read)
   );

   int errors = 0;
   int checks = 0;
   bit cmp_en = 1'b0;
   bit saw_drive = 1'b0;

   // Behavioural reference state
   logic [7:0] mw [WD];
   logic [7:0] m_last = 8'h00, m_gc = 8'h00;
   bit         m_rdb = 1'b0, m_wrb = 1'b0, m_wasr = 1'b0;
   int         m_ptr = 0;

   function automatic logic [7:0] rval(int i);
      return 8'(8'h30 + i * 7);
   endfunction

   task automatic chk(string req, string what, longint act, longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // Per-clock comparison against the reference during settled windows
   always @(negedge clk) begin
      if (cmp_en) begin
         chk("R3", "last_ptr", last_ptr, m_last);
         chk("R9", "gc_cmd", gc_cmd, m_gc);
         chk("R5", "rd_busy", rd_busy, m_rdb);
         chk("R8", "wr_busy", wr_busy, m_wrb);
         chk("R7", "data_was_read", data_was_read, m_wasr);
         for (int i = 0; i < WD; i++)
            chk("R4", $sformatf("wr_bank[%0d]", i), wr_bank[i*8 +: 8], mw[i]);
      end
      if (sda_oe) saw_drive = 1'b1;
   end

   task automatic wt(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic sync_cmp();
      cmp_en = 1'b1;
      wt(3);
      cmp_en = 1'b0;
   endtask

   task automatic bus_start();
      m_sda = 1'b1; wt(H);
      m_scl = 1'b1; wt(H);
      m_sda = 1'b0; wt(H);
      m_scl = 1'b0; wt(H);
   endtask

   task automatic bus_stop();
      m_sda = 1'b0; wt(H);
      m_scl = 1'b1; wt(H);
      m_sda = 1'b1; wt(H);
   endtask

   task automatic wr_byte(input logic [7:0] b, output bit acked);
      for (int i = 7; i >= 0; i--) begin
         m_sda = b[i]; wt(H);
         m_scl = 1'b1; wt(H);
         m_scl = 1'b0;
      end
      m_sda = 1'b1; wt(H);
      m_scl = 1'b1; wt(H/2);
      acked = !bus_sda;
      wt(H/2);
      m_scl = 1'b0;
   endtask

   task automatic rd_byte(input bit ack, output logic [7:0] b);
      m_sda = 1'b1;
      b = 8'h00;
      for (int i = 0; i < 8; i++) begin
         wt(H);
         m_scl = 1'b1; wt(H/2);
         b = {b[6:0], bus_sda};
         wt(H/2);
         m_scl = 1'b0;
      end
      m_sda = ack ? 1'b0 : 1'b1; wt(H);
      m_scl = 1'b1; wt(H);
      m_scl = 1'b0;
   endtask

   task automatic set_ptr(input logic [7:0] p);
      bit a;
      wr_byte(p, a);
      chk("R3", "pointer byte ack", a, 1);
      m_ptr = p; m_last = p;
      sync_cmp();
   endtask

   task automatic wr_data(input logic [7:0] d);
      bit a;
      wr_byte(d, a);
      chk("R4", "data byte ack", a, 1);
      mw[m_ptr % WD] = d;
      m_ptr = (m_ptr + 1) % 256;
      sync_cmp();
   endtask

   task automatic own_write_addr();
      bit a;
      wr_byte({cfg_addr[7:1], 1'b0}, a);
      chk("R2", "own write address ack", a, 1);
      m_wrb = 1'b1;
      sync_cmp();
   endtask

   task automatic rd_expect(input bit ack, string req);
      logic [7:0] b;
      rd_byte(ack, b);
      chk(req, $sformatf("read byte at ptr %0d", m_ptr), b, rval(m_ptr % RD));
      m_ptr = (m_ptr + 1) % 256;
      if (!ack) begin
         m_rdb = 1'b0; m_wasr = 1'b1; m_ptr = 0;
      end
      sync_cmp();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog all requirements actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      bit a;
      for (int i = 0; i < RD; i++) rd_bank[i*8 +: 8] = rval(i);
      for (int i = 0; i < WD; i++) mw[i] = 8'h00;
      wt(5);
      rst_n = 1'b1;
      wt(5);

      // R10: reset state
      chk("R10", "sda_oe after reset", sda_oe, 0);
      sync_cmp();

      // R3 R4 R8: plain write of two bytes at pointer 3
      bus_start();
      own_write_addr();
      set_ptr(8'h03);
      wr_data(8'h11);
      wr_data(8'h22);
      bus_stop();
      m_wrb = 1'b0;
      sync_cmp();

      // R4: write crossing the bank end wraps to entry 0
      bus_start();
      own_write_addr();
      set_ptr(8'h0F);
      wr_data(8'hAA);
      wr_data(8'hBB);
      bus_stop();
      m_wrb = 1'b0;
      sync_cmp();

      // R5 R6 R8: pointer write, repeated START, read three bytes
      bus_start();
      own_write_addr();
      set_ptr(8'h05);
      bus_start();
      m_wrb = 1'b0;            // R8: repeated START clears write-busy
      sync_cmp();
      wr_byte({cfg_addr[7:1], 1'b1}, a);
      chk("R5", "own read address ack", a, 1);
      m_rdb = 1'b1;
      sync_cmp();
      rd_expect(1'b1, "R5");
      rd_expect(1'b1, "R5");
      rd_expect(1'b0, "R5");
      chk("R6", "sda released after NACK", sda_oe, 0);
      bus_stop();
      sync_cmp();

      // R6: pointer returned to 0 by the NACK
      bus_start();
      wr_byte({cfg_addr[7:1], 1'b1}, a);
      chk("R6", "read address ack", a, 1);
      m_rdb = 1'b1;
      rd_expect(1'b0, "R6");
      bus_stop();
      sync_cmp();

      // R7: flag held, then cleared by a pulse
      wt(20);
      sync_cmp();
      clr_was_read = 1'b1; wt(1);
      clr_was_read = 1'b0; wt(1);
      m_wasr = 1'b0;
      sync_cmp();

      // R5: read crossing the read-bank end
      bus_start();
      own_write_addr();
      set_ptr(8'h1F);
      bus_start();
      m_wrb = 1'b0;
      wr_byte({cfg_addr[7:1], 1'b1}, a);
      chk("R5", "read address ack", a, 1);
      m_rdb = 1'b1;
      rd_expect(1'b1, "R5");
      rd_expect(1'b0, "R5");
      bus_stop();
      sync_cmp();

      // R2: foreign address ignored, no drive, no state change
      saw_drive = 1'b0;
      bus_start();
      wr_byte(8'h40, a);
      chk("R2", "foreign address nack", a, 0);
      wr_byte(8'h07, a);
      chk("R2", "byte after foreign address nack", a, 0);
      wr_byte(8'h99, a);
      bus_stop();
      chk("R2", "SDA never driven", saw_drive, 0);
      sync_cmp();

      // R9: general call to the command register
      bus_start();
      wr_byte(8'h00, a);
      chk("R9", "general call ack", a, 1);
      wr_byte(8'h5A, a);
      chk("R9", "gc byte ack", a, 1);
      m_gc = 8'h5A;
      sync_cmp();
      wr_byte(8'hC3, a);
      chk("R9", "gc byte ack", a, 1);
      m_gc = 8'hC3;
      bus_stop();
      sync_cmp();

      // R1: general call disabled by cfg_addr[0] = 0
      cfg_addr = 8'h54;
      saw_drive = 1'b0;
      bus_start();
      wr_byte(8'h00, a);
      chk("R1", "general call refused", a, 0);
      wr_byte(8'h99, a);
      bus_stop();
      chk("R1", "no drive with gc disabled", saw_drive, 0);
      sync_cmp();

      // R1: new address in cfg_addr[7:1]
      cfg_addr = 8'h61;
      bus_start();
      wr_byte(8'h54, a);
      chk("R1", "old address refused", a, 0);
      bus_stop();
      bus_start();
      wr_byte(8'h60, a);
      chk("R1", "new address accepted", a, 1);
      m_wrb = 1'b1;
      sync_cmp();
      set_ptr(8'h09);
      wr_data(8'h77);
      bus_stop();
      m_wrb = 1'b0;
      sync_cmp();
      chk("R10", "sda released at end", sda_oe, 0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule